// File: doc/BRIEF.md
# Box Grade Majority Classifier

The classifier receives the 8-bit codes of the five products packed in one box and returns a 2-bit category for the whole box. Each product is graded by how many of its code bits are zero. A product with many zero bits earns a better grade. The block counts how many products land in each grade and reports the grade held by the most products. When several grades share that largest count, the better grade wins.

The block is purely combinational and has no clock or reset. Its top level only wires instances together. One grader per product counts zero bits and maps the count to a grade. A tally stage counts products per grade, and a select stage picks the winner. Product count, code width and the grade thresholds are parameters.

Products are packed into one bus, with product 0 in the lowest byte. Grade codes are A=0, B=1, C=2 and D=3. The output carries the code of the winning grade.

Top module: `box_grade_classifier`

## Requirements
- R1: A product code with 7 or 8 zero bits is graded A (code 0).
- R2: A product code with 5 or 6 zero bits is graded B (code 1).
- R3: A product code with 3 or 4 zero bits is graded C (code 2).
- R4: A product code with 0, 1 or 2 zero bits is graded D (code 3).
- R5: box_grade_o carries the code of the grade held by the largest number of the five products.
- R6: When two or more grades share the largest product count, box_grade_o carries the better of them, where A beats B, B beats C and C beats D.
- R7: box_grade_o follows prod_codes_i with no clock edge in between. A new input value is reflected in the same time step.
- R8: The category does not depend on which byte lane holds which product. Any rotation of the five codes gives the same output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| prod_codes_i | input | 40 | Five product codes; product p occupies bits 8p+7 down to 8p |
| box_grade_o | output | 2 | Box category: 0=A, 1=B, 2=C, 3=D |

## Verification
Every result is due in the same time step as its stimulus, because no register lies between prod_codes_i and box_grade_o. The bench drives a new vector at a falling clock edge and samples the output one time unit later, with no clock edge in between. The R7 check goes further: it changes the inputs twice within one clock phase and expects the output to follow each change. The clock only paces the vectors and feeds the watchdog.

// File: rtl/box_grade_pkg.sv
package box_grade_pkg;
  typedef enum logic [1:0] {
    GRADE_A = 2'd0,
    GRADE_B = 2'd1,
    GRADE_C = 2'd2,
    GRADE_D = 2'd3
  } grade_e;

  localparam int NUM_GRADES = 4;
  localparam int GRADE_W    = 2;
endpackage

// File: rtl/zero_counter.sv
module zero_counter #(
  parameter int CODE_W = 8,
  localparam int ZCNT_W = $clog2(CODE_W + 1)
) (
  input  logic [CODE_W-1:0] code_i,
  output logic [ZCNT_W-1:0] zeros_o
);
  always_comb begin
    zeros_o = '0;
    for (int i = 0; i < CODE_W; i++) begin
      zeros_o = zeros_o + ZCNT_W'(~code_i[i]);
    end
  end
endmodule

// File: rtl/grade_mapper.sv
module grade_mapper
  import box_grade_pkg::*;
#(
  parameter int CODE_W      = 8,
  parameter int A_MIN_ZEROS = 7,
  parameter int B_MIN_ZEROS = 5,
  parameter int C_MIN_ZEROS = 3,
  localparam int ZCNT_W = $clog2(CODE_W + 1)
) (
  input  logic [ZCNT_W-1:0] zeros_i,
  output grade_e            grade_o
);
  localparam logic [ZCNT_W-1:0] A_TH = ZCNT_W'(A_MIN_ZEROS);
  localparam logic [ZCNT_W-1:0] B_TH = ZCNT_W'(B_MIN_ZEROS);
  localparam logic [ZCNT_W-1:0] C_TH = ZCNT_W'(C_MIN_ZEROS);

  always_comb begin
    if (zeros_i >= A_TH)      grade_o = GRADE_A;
    else if (zeros_i >= B_TH) grade_o = GRADE_B;
    else if (zeros_i >= C_TH) grade_o = GRADE_C;
    else                      grade_o = GRADE_D;
  end
endmodule

// File: rtl/product_grader.sv
module product_grader
  import box_grade_pkg::*;
#(
  parameter int CODE_W      = 8,
  parameter int A_MIN_ZEROS = 7,
  parameter int B_MIN_ZEROS = 5,
  parameter int C_MIN_ZEROS = 3
) (
  input  logic [CODE_W-1:0]  code_i,
  output logic [GRADE_W-1:0] grade_o
);
  localparam int ZCNT_W = $clog2(CODE_W + 1);

  logic [ZCNT_W-1:0] zeros;
  grade_e            grade;

  zero_counter #(.CODE_W(CODE_W)) u_zcnt (
    .code_i (code_i),
    .zeros_o(zeros)
  );

  grade_mapper #(
    .CODE_W     (CODE_W),
    .A_MIN_ZEROS(A_MIN_ZEROS),
    .B_MIN_ZEROS(B_MIN_ZEROS),
    .C_MIN_ZEROS(C_MIN_ZEROS)
  ) u_map (
    .zeros_i(zeros),
    .grade_o(grade)
  );

  assign grade_o = grade;

  // zero count from the counter checked against the mapper's grade
  always_comb begin
    if (int'(zeros) >= A_MIN_ZEROS)
      AST_GRADE_A_BAND: assert (grade == GRADE_A) else $error("grade A band"); // R1
    if (int'(zeros) >= B_MIN_ZEROS && int'(zeros) < A_MIN_ZEROS)
      AST_GRADE_B_BAND: assert (grade == GRADE_B) else $error("grade B band"); // R2
    if (int'(zeros) >= C_MIN_ZEROS && int'(zeros) < B_MIN_ZEROS)
      AST_GRADE_C_BAND: assert (grade == GRADE_C) else $error("grade C band"); // R3
    if (int'(zeros) < C_MIN_ZEROS)
      AST_GRADE_D_BAND: assert (grade == GRADE_D) else $error("grade D band"); // R4
  end
endmodule

// File: rtl/grade_tally.sv
module grade_tally
  import box_grade_pkg::*;
#(
  parameter int NUM_PRODUCTS = 5,
  localparam int TALLY_W = $clog2(NUM_PRODUCTS + 1)
) (
  input  logic [NUM_PRODUCTS-1:0][GRADE_W-1:0] grades_i,
  output logic [NUM_GRADES-1:0][TALLY_W-1:0]   tallies_o
);
  always_comb begin
    for (int g = 0; g < NUM_GRADES; g++) begin
      tallies_o[g] = '0;
      for (int p = 0; p < NUM_PRODUCTS; p++) begin
        if (grades_i[p] == GRADE_W'(g)) tallies_o[g] = tallies_o[g] + TALLY_W'(1);
      end
    end
  end

  // every product lands in exactly one grade
  always_comb begin
    int total;
    total = 0;
    for (int g = 0; g < NUM_GRADES; g++) total = total + int'(tallies_o[g]);
    AST_TALLY_TOTAL: assert (total == NUM_PRODUCTS) else $error("tally total"); // R5
  end
endmodule

// File: rtl/grade_select.sv
module grade_select
  import box_grade_pkg::*;
#(
  parameter int NUM_PRODUCTS = 5,
  localparam int TALLY_W = $clog2(NUM_PRODUCTS + 1)
) (
  input  logic [NUM_GRADES-1:0][TALLY_W-1:0] tallies_i,
  output logic [GRADE_W-1:0]                 sel_o
);
  // scan from the best grade; only a strictly larger tally displaces the leader
  always_comb begin
    sel_o = '0;
    for (int g = 1; g < NUM_GRADES; g++) begin
      if (tallies_i[g] > tallies_i[sel_o]) sel_o = GRADE_W'(g);
    end
  end

  always_comb begin
    for (int g = 0; g < NUM_GRADES; g++) begin
      AST_SEL_IS_MAX: assert (tallies_i[g] <= tallies_i[sel_o]) else $error("not max"); // R5
      if (GRADE_W'(g) < sel_o)
        AST_TIE_TO_BETTER: assert (tallies_i[g] < tallies_i[sel_o]) else $error("tie lost"); // R6
    end
  end
endmodule

// File: rtl/box_grade_classifier.sv
module box_grade_classifier
  import box_grade_pkg::*;
#(
  parameter int NUM_PRODUCTS = 5,
  parameter int CODE_W       = 8,
  parameter int A_MIN_ZEROS  = 7,
  parameter int B_MIN_ZEROS  = 5,
  parameter int C_MIN_ZEROS  = 3
) (
  input  logic [NUM_PRODUCTS*CODE_W-1:0] prod_codes_i,
  output logic [1:0]                     box_grade_o
);
  localparam int TALLY_W = $clog2(NUM_PRODUCTS + 1);

  logic [NUM_PRODUCTS-1:0][GRADE_W-1:0] grades;
  logic [NUM_GRADES-1:0][TALLY_W-1:0]   tallies;

  for (genvar p = 0; p < NUM_PRODUCTS; p++) begin : g_prod
    product_grader #(
      .CODE_W     (CODE_W),
      .A_MIN_ZEROS(A_MIN_ZEROS),
      .B_MIN_ZEROS(B_MIN_ZEROS),
      .C_MIN_ZEROS(C_MIN_ZEROS)
    ) u_grader (
      .code_i (prod_codes_i[p*CODE_W +: CODE_W]),
      .grade_o(grades[p])
    );
  end

  grade_tally #(.NUM_PRODUCTS(NUM_PRODUCTS)) u_tally (
    .grades_i (grades),
    .tallies_o(tallies)
  );

  grade_select #(.NUM_PRODUCTS(NUM_PRODUCTS)) u_select (
    .tallies_i(tallies),
    .sel_o    (box_grade_o)
  );
endmodule

// File: tb/box_grade_classifier_tb.sv
`timescale 1ns/1ps
module box_grade_classifier_tb;
  localparam int NP = 5;
  localparam int CW = 8;

  logic clk = 1'b0;
  logic [NP*CW-1:0] codes;
  logic [1:0] grade;
  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  box_grade_classifier u_dut (
    .prod_codes_i(codes),
    .box_grade_o (grade)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      errors++;
      $display("FAIL watchdog: run hung, got %0d cycles, expected fewer than 20000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  function automatic logic [NP*CW-1:0] pack5(input logic [7:0] p0, p1, p2, p3, p4);
    return {p4, p3, p2, p1, p0};
  endfunction

  // reference: grade bands by zero count, most common grade, ties to better
  function automatic logic [1:0] ref_box(input logic [NP*CW-1:0] c);
    int t[4];
    int best;
    for (int g = 0; g < 4; g++) t[g] = 0;
    for (int p = 0; p < NP; p++) begin
      int z;
      z = CW - $countones(c[p*CW +: CW]);
      if (z >= 7) t[0]++;
      else if (z >= 5) t[1]++;
      else if (z >= 3) t[2]++;
      else t[3]++;
    end
    best = 0;
    for (int g = 1; g < 4; g++) if (t[g] > t[best]) best = g;
    return 2'(best);
  endfunction

  task automatic check(input string req, input logic [1:0] exp, input string what);
    checks++;
    if (grade !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, grade, exp);
    end
  endtask

  task automatic apply(input logic [NP*CW-1:0] c);
    @(negedge clk);
    codes = c;
    #1;
  endtask

  task automatic test_examples();
    apply(pack5(8'b00000001, 8'b00000000, 8'b00011111, 8'b01010101, 8'b00100000));
    check("R5", 2'd0, "three A products");
    apply(pack5(8'b10100000, 8'b10110100, 8'b00000111, 8'b01101011, 8'b00001000));
    check("R6", 2'd1, "B and C tied at two");
    apply(pack5(8'b11001110, 8'b01101010, 8'b01111000, 8'b01111111, 8'b00110111));
    check("R5", 2'd2, "four C products");
    apply(pack5(8'b11111111, 8'b11011111, 8'b11101101, 8'b11111101, 8'b01111111));
    check("R5", 2'd3, "all D products");
    apply(pack5(8'b01101101, 8'b11111111, 8'b11111111, 8'b00000000, 8'b11011101));
    check("R5", 2'd3, "three D products");
  endtask

  // all five products share one zero count: every band edge
  task automatic test_bands();
    logic [7:0] code;
    logic [1:0] exp;
    string req;
    for (int z = 0; z <= 8; z++) begin
      code = 8'hFF << z;
      if (z >= 7)      begin exp = 2'd0; req = "R1"; end
      else if (z >= 5) begin exp = 2'd1; req = "R2"; end
      else if (z >= 3) begin exp = 2'd2; req = "R3"; end
      else             begin exp = 2'd3; req = "R4"; end
      apply({NP{code}});
      check(req, exp, $sformatf("uniform box with %0d zeros", z));
    end
  endtask

  task automatic test_ties();
    // A2 D2 C1 -> A
    apply(pack5(8'h00, 8'hFF, 8'h01, 8'h7F, 8'h0F));
    check("R6", 2'd0, "A ties D");
    // B2 D2 A1 -> B
    apply(pack5(8'h03, 8'hFF, 8'h07, 8'h3F, 8'h00));
    check("R6", 2'd1, "B ties D");
    // C2 D2 B1 -> C
    apply(pack5(8'hFF, 8'h0F, 8'h3F, 8'h1F, 8'h03));
    check("R6", 2'd2, "C ties D");
    // B2 C2 D1 -> B
    apply(pack5(8'h1F, 8'h03, 8'hFF, 8'h07, 8'h0F));
    check("R6", 2'd1, "B ties C");
  endtask

  task automatic test_order();
    logic [7:0] base [NP];
    logic [NP*CW-1:0] c;
    base[0] = 8'b10100000; base[1] = 8'b10110100; base[2] = 8'b00000111;
    base[3] = 8'b01101011; base[4] = 8'b00001000;
    for (int k = 0; k < NP; k++) begin
      for (int j = 0; j < NP; j++) c[j*CW +: CW] = base[(j + k) % NP];
      apply(c);
      check("R8", 2'd1, $sformatf("rotation %0d", k));
    end
  endtask

  task automatic test_comb();
    @(negedge clk);
    codes = {NP{8'h00}};
    #1 check("R7", 2'd0, "first change without edge");
    codes = {NP{8'hFF}};
    #1 check("R7", 2'd3, "second change without edge");
    codes = {NP{8'h07}};
    #1 check("R7", 2'd1, "third change without edge");
  endtask

  task automatic test_random();
    logic [NP*CW-1:0] c;
    for (int i = 0; i < 300; i++) begin
      for (int p = 0; p < NP; p++) c[p*CW +: CW] = 8'($urandom);
      apply(c);
      check("R5", ref_box(c), $sformatf("random vector %0d", i));
    end
  endtask

  initial begin
    codes = '0;
    test_examples();
    test_bands();
    test_ties();
    test_order();
    test_comb();
    test_random();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule